// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

A timekeeping core for a real-time clock. It holds seconds, minutes, hours, day of month, month, two-digit year (taken as 20xx) and a day-of-week counter, every field in packed BCD. A one-cycle enable pulse, produced elsewhere once per second, advances the time while the clock runs. Carries between fields resolve on the same tick, and the day field follows month lengths and leap years.

Software reaches the core through a byte-wide register port with a synchronous write strobe and a registered read. Time reads do not return the live counters. They return a shadow copy, which is refreshed only on request, so a burst of reads across the fields stays coherent even if a tick lands in the middle. The time fields accept writes only while the clock is stopped. A six-field alarm comparator raises a single-cycle pulse when an advance lands exactly on the programmed date and time.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time is 00:00:00 on day 01, month 01, year 00. The weekday is 00, the clock is stopped and all six alarm bytes are 0x00. Because the alarm month is then 00, it cannot match. `reg_rdata` and `alarm_hit` are 0.
- R2: Register offsets are as follows. Time fields: seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06. Alarm fields: seconds through year at 0x07 to 0x0C. Control: 0x0D. `reg_rdata` shows the register at `reg_addr` one cycle later. Any other offset reads 0x00. A control read returns the run bit in bit 0 and zeros elsewhere.
- R3: Control bit 0 set to 1 runs the clock, and each `tick_1hz` cycle then advances the time by one second. When it is 0, ticks leave the time unchanged.
- R4: A write to offsets 0x00 to 0x06 takes effect only while the clock is stopped. While the clock runs it is ignored.
- R5: A control write with bit 6 set copies all seven live fields, as they stood before that edge, into the read copy. Reads of offsets 0x00 to 0x06 return that copy until the next such write. Bit 6 is not stored.
- R6: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. Every carry ripples into the next field on the same tick.
- R7: The day wraps to 01 after 31, 30, 29 or 28 according to the month. February has 29 days when the year is divisible by 4 (year 00 included).
- R8: The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R9: The weekday counts 00 to 06, advances when the hours wrap, and wraps from 06 to 00.
- R10: `alarm_hit` is high for exactly one cycle, the cycle after an advancing edge whose new time equals all six alarm fields. Alarm registers read back directly, not through the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle advance pulse, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's offset |
| alarm_hit | output | 1 | Single-cycle alarm match pulse |

## Verification
Each result has a fixed latency, and the bench samples it there. Read data appears one cycle after the offset is presented. A time advance and the `alarm_hit` pulse are both visible right after the rising edge that samples the tick. A copy request takes effect at the edge of its control write, so reads issued from the next cycle return the new copy. The behavioural model applies inputs at each rising edge in that order: read first, then copy, advance, write. Its predictions of `reg_rdata` and `alarm_hit` are compared on the falling edge that follows, and the directed reads are sampled at the same point.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int N_TIME = 6;               // fields shared with the alarm
  localparam int N_LIVE = N_TIME + 1;      // plus weekday
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YR   = 5;
  localparam int F_WDAY = 6;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 6;
  localparam int REG_ALARM_BASE = 7;
  localparam int REG_CTRL       = 13;

  typedef logic [BYTE_W-1:0] bcd_t;

  // lowest legal value of a field; also its reset value
  function automatic bcd_t field_lo(int f);
    return (f == F_DAY || f == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // highest legal value (day is replaced by the month length)
  function automatic bcd_t field_hi(int f);
    case (f)
      F_SEC, F_MIN: return 8'h59;
      F_HR:         return 8'h23;
      F_DAY:        return 8'h31;
      F_MON:        return 8'h12;
      F_YR:         return 8'h99;
      default:      return 8'h06;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
(
  input  bcd_t val,
  input  bcd_t lo,
  input  bcd_t hi,
  input  logic inc,
  output bcd_t nxt,
  output logic wrap
);
  logic at_top;
  assign at_top = (val >= hi);   // also pulls an out-of-range value back
  assign wrap   = inc & at_top;

  always_comb begin
    if (!inc)
      nxt = val;
    else if (at_top)
      nxt = lo;
    else if (val[3:0] >= 4'd9)
      nxt = {val[7:4] + 4'd1, 4'h0};
    else
      nxt = {val[7:4], val[3:0] + 4'd1};
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  bcd_t mon,
  input  bcd_t yr,
  output bcd_t last_day
);
  logic leap;
  // 10*t + o is a multiple of 4 when o is even and t[0] equals o[1]
  assign leap = ~yr[0] & (yr[4] == yr[1]);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
#(
  parameter int N = N_TIME
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic [N-1:0][BYTE_W-1:0] next_time,
  input  logic [N-1:0][BYTE_W-1:0] alarm,
  output logic                     hit
);
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= adv && (next_time == alarm);
  end

  assert_hit_single_R10: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  assert_hit_after_adv_R10: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(adv));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              alarm_hit
);
  localparam int IDX_W     = $clog2(N_LIVE);
  localparam int ALM_IDX_W = $clog2(N_TIME);
  localparam logic [ADDR_W-1:0] A_LIVE_END = ADDR_W'(N_LIVE);
  localparam logic [ADDR_W-1:0] A_ALM_LO   = ADDR_W'(REG_ALARM_BASE);
  localparam logic [ADDR_W-1:0] A_ALM_END  = ADDR_W'(REG_ALARM_BASE + N_TIME);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(REG_CTRL);

  logic [N_LIVE-1:0][BYTE_W-1:0] live_q, live_nxt, shadow_q;
  logic [N_TIME-1:0][BYTE_W-1:0] alarm_q;
  logic [N_LIVE-1:0]             fld_inc, fld_wrap;
  bcd_t                          day_last;
  logic                          run_q, adv;
  logic                          sel_live, sel_alm, sel_ctrl, wr_time, snap_req;
  logic [ALM_IDX_W-1:0]          alm_idx;
  logic                          wrap_unused;

  assign adv      = tick_1hz & run_q;
  assign sel_live = reg_addr < A_LIVE_END;
  assign sel_alm  = (reg_addr >= A_ALM_LO) && (reg_addr < A_ALM_END);
  assign sel_ctrl = reg_addr == A_CTRL;
  assign wr_time  = reg_wr & sel_live & ~run_q;
  assign snap_req = reg_wr & sel_ctrl & reg_wdata[CTRL_SNAP];
  assign alm_idx  = ALM_IDX_W'(reg_addr - A_ALM_LO);
  assign wrap_unused = fld_wrap[F_YR] | fld_wrap[F_WDAY];

  rtc_month_len u_mlen (
    .mon      (live_q[F_MON]),
    .yr       (live_q[F_YR]),
    .last_day (day_last)
  );

  // carry chain: sec -> min -> hr -> day -> mon -> yr ; hr wrap -> weekday
  for (genvar f = 0; f < N_LIVE; f++) begin : g_field
    bcd_t hi_f;
    if (f == F_DAY) begin : g_hi_dyn
      assign hi_f = day_last;
    end else begin : g_hi_fix
      assign hi_f = field_hi(f);
    end
    if (f == F_SEC) begin : g_inc_tick
      assign fld_inc[f] = adv;
    end else if (f == F_WDAY) begin : g_inc_wday
      assign fld_inc[f] = fld_wrap[F_HR];
    end else begin : g_inc_carry
      assign fld_inc[f] = fld_wrap[f-1];
    end
    rtc_bcd_field u_fld (
      .val  (live_q[f]),
      .lo   (field_lo(f)),
      .hi   (hi_f),
      .inc  (fld_inc[f]),
      .nxt  (live_nxt[f]),
      .wrap (fld_wrap[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < N_LIVE; f++) begin
        live_q[f]   <= field_lo(f);
        shadow_q[f] <= field_lo(f);
      end
      alarm_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (snap_req) shadow_q <= live_q;
      if (adv)
        live_q <= live_nxt;
      else if (wr_time)
        live_q[reg_addr[IDX_W-1:0]] <= reg_wdata;
      if (reg_wr && sel_alm) alarm_q[alm_idx] <= reg_wdata;
      if (reg_wr && sel_ctrl) run_q <= reg_wdata[CTRL_RUN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata <= '0;
    else if (sel_live) reg_rdata <= shadow_q[reg_addr[IDX_W-1:0]];
    else if (sel_alm)  reg_rdata <= alarm_q[alm_idx];
    else if (sel_ctrl) reg_rdata <= {{(BYTE_W-1){1'b0}}, run_q};
    else               reg_rdata <= '0;
  end

  rtc_alarm_cmp #(.N(N_TIME)) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .next_time (live_nxt[N_TIME-1:0]),
    .alarm     (alarm_q),
    .hit       (alarm_hit)
  );

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(reg_wr && reg_addr < A_LIVE_END)) |=> $stable(live_q));
  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick_1hz && reg_wr && reg_addr < A_LIVE_END) |=> $stable(live_q));
  assert_snapshot_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_SNAP]) |=> (shadow_q == $past(live_q)));
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_1hz && live_q[F_SEC] == 8'h59) |=> (live_q[F_SEC] == 8'h00));
  assert_year_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    fld_wrap[F_YR] |=> (live_q[F_YR] == 8'h00 && live_q[F_MON] == 8'h01));
  assert_wday_range_R9: assert property (@(posedge clk) disable iff (rst)
    fld_wrap[F_WDAY] |=> (live_q[F_WDAY] == 8'h00));
endmodule

// File: tb/rtc_bcd_calendar_test.sv
module rtc_bcd_calendar_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_hit;

  int    checks = 0;
  int    fails  = 0;
  bit    cmp_on = 0;
  bit    done   = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rtc_bcd_calendar uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_hit(alarm_hit)
  );

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(int mon, int yr);
    case (mon)
      2:            return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11:  return 30;
      default:      return 31;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_t [7];   // binary: sec min hr day mon yr wday
  int         m_sh[7];
  logic [7:0] m_al[6];
  bit         m_run;
  logic [7:0] exp_rd;
  logic       exp_hit;
  int         ma;
  logic       nh;

  always @(posedge clk) begin
    if (rst) begin
      m_t  = '{0, 0, 0, 1, 1, 0, 0};
      m_sh = '{0, 0, 0, 1, 1, 0, 0};
      for (int i = 0; i < 6; i++) m_al[i] = 8'h00;
      m_run = 0; exp_rd = 8'h00; exp_hit = 1'b0;
    end else begin
      ma = int'(reg_addr);
      if (ma < 7)                 exp_rd = tobcd(m_sh[ma]);
      else if (ma < 13)           exp_rd = m_al[ma-7];
      else if (ma == 13)          exp_rd = {7'b0, m_run};
      else                        exp_rd = 8'h00;
      if (reg_wr && ma == 13 && reg_wdata[6])
        for (int i = 0; i < 7; i++) m_sh[i] = m_t[i];
      nh = 1'b0;
      if (tick_1hz && m_run) begin
        m_t[0]++;
        if (m_t[0] == 60) begin
          m_t[0] = 0; m_t[1]++;
          if (m_t[1] == 60) begin
            m_t[1] = 0; m_t[2]++;
            if (m_t[2] == 24) begin
              m_t[2] = 0; m_t[6] = (m_t[6] + 1) % 7; m_t[3]++;
              if (m_t[3] > dim(m_t[4], m_t[5])) begin
                m_t[3] = 1; m_t[4]++;
                if (m_t[4] == 13) begin m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100; end
              end
            end
          end
        end
        nh = 1'b1;
        for (int i = 0; i < 6; i++) if (tobcd(m_t[i]) != m_al[i]) nh = 1'b0;
      end else if (reg_wr && !m_run && ma < 7) begin
        m_t[ma] = frombcd(reg_wdata);
      end
      exp_hit = nh;
      if (reg_wr && ma >= 7 && ma < 13) m_al[ma-7] = reg_wdata;
      if (reg_wr && ma == 13) m_run = reg_wdata[0];
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "model rdata", reg_rdata, exp_rd);
      chk(cur_req, "model alarm_hit", {7'b0, alarm_hit}, {7'b0, exp_hit});
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(logic [4:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic expect_rd(string req, logic [4:0] a, logic [7:0] e);
    reg_addr = a;
    @(negedge clk);
    chk(req, $sformatf("read 0x%02h", a), reg_rdata, e);
  endtask
  task automatic tick_n(int n);
    tick_1hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_1hz = 1'b0;
  endtask
  task automatic snap(bit run);
    wr(5'h0D, {1'b0, 1'b1, 5'b0, run});
  endtask
  task automatic set_time(int y, int mo, int d, int h, int mi, int s);
    wr(5'h0D, 8'h00);
    wr(5'h00, tobcd(s));  wr(5'h01, tobcd(mi)); wr(5'h02, tobcd(h));
    wr(5'h03, tobcd(d));  wr(5'h04, tobcd(mo)); wr(5'h05, tobcd(y));
    wr(5'h0D, 8'h01);
  endtask
  task automatic expect_date(string req, logic [7:0] y, logic [7:0] mo, logic [7:0] d);
    snap(1);
    expect_rd(req, 5'h03, d);
    expect_rd(req, 5'h04, mo);
    expect_rd(req, 5'h05, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;

    // R1: reset state
    cur_req = "R1";
    chk("R1", "alarm_hit after reset", {7'b0, alarm_hit}, 8'h00);
    expect_rd("R1", 5'h0D, 8'h00);
    expect_rd("R1", 5'h00, 8'h00);
    expect_rd("R1", 5'h02, 8'h00);
    expect_rd("R1", 5'h03, 8'h01);
    expect_rd("R1", 5'h04, 8'h01);
    expect_rd("R1", 5'h05, 8'h00);
    expect_rd("R1", 5'h0B, 8'h00);

    // R3: ticks while stopped do nothing, run enables counting
    cur_req = "R3";
    tick_n(3);
    snap(0);
    expect_rd("R3", 5'h00, 8'h00);
    wr(5'h0D, 8'h01);
    tick_n(5);
    snap(1);
    expect_rd("R3", 5'h00, 8'h05);

    // R5: copy stays frozen until the next request
    cur_req = "R5";
    tick_n(3);
    expect_rd("R5", 5'h00, 8'h05);
    snap(1);
    expect_rd("R5", 5'h00, 8'h08);

    // R2: unmapped offsets and control readback
    cur_req = "R2";
    expect_rd("R2", 5'h1F, 8'h00);
    expect_rd("R2", 5'h0E, 8'h00);
    expect_rd("R2", 5'h0D, 8'h01);

    // R4: time writes ignored while running
    cur_req = "R4";
    wr(5'h00, 8'h30);
    snap(1);
    expect_rd("R4", 5'h00, 8'h08);
    wr(5'h0D, 8'h00);
    wr(5'h00, 8'h30);
    snap(0);
    expect_rd("R4", 5'h00, 8'h30);
    wr(5'h0D, 8'h01);

    // R6: ripple of every carry on one tick, plus a long run
    cur_req = "R6";
    set_time(23, 12, 31, 23, 59, 58);
    tick_n(1);
    snap(1);
    expect_rd("R6", 5'h00, 8'h59);
    expect_rd("R6", 5'h01, 8'h59);
    tick_n(1);
    snap(1);
    expect_rd("R6", 5'h00, 8'h00);
    expect_rd("R6", 5'h01, 8'h00);
    expect_rd("R6", 5'h02, 8'h00);
    expect_date("R8", 8'h24, 8'h01, 8'h01);
    set_time(10, 5, 5, 0, 0, 0);
    tick_n(3700);
    snap(1);
    expect_rd("R6", 5'h02, 8'h01);
    expect_rd("R6", 5'h01, 8'h01);
    expect_rd("R6", 5'h00, 8'h40);

    // R7: month lengths and leap years
    cur_req = "R7";
    set_time(24, 2, 28, 23, 59, 59); tick_n(1); expect_date("R7", 8'h24, 8'h02, 8'h29);
    set_time(24, 2, 29, 23, 59, 59); tick_n(1); expect_date("R7", 8'h24, 8'h03, 8'h01);
    set_time(23, 2, 28, 23, 59, 59); tick_n(1); expect_date("R7", 8'h23, 8'h03, 8'h01);
    set_time(0, 2, 28, 23, 59, 59);  tick_n(1); expect_date("R7", 8'h00, 8'h02, 8'h29);
    set_time(21, 4, 30, 23, 59, 59); tick_n(1); expect_date("R7", 8'h21, 8'h05, 8'h01);
    set_time(21, 1, 30, 23, 59, 59); tick_n(1); expect_date("R7", 8'h21, 8'h01, 8'h31);

    // R8: century wrap
    cur_req = "R8";
    set_time(99, 12, 31, 23, 59, 59); tick_n(1); expect_date("R8", 8'h00, 8'h01, 8'h01);

    // R9: weekday wraps 06 -> 00 on the hour wrap
    cur_req = "R9";
    wr(5'h0D, 8'h00);
    wr(5'h06, 8'h06);
    set_time(30, 7, 7, 23, 59, 59);
    tick_n(1);
    snap(1);
    expect_rd("R9", 5'h06, 8'h00);

    // R10: alarm match pulse
    cur_req = "R10";
    set_time(25, 6, 15, 10, 20, 30);
    wr(5'h07, 8'h33); wr(5'h08, 8'h20); wr(5'h09, 8'h10);
    wr(5'h0A, 8'h15); wr(5'h0B, 8'h06); wr(5'h0C, 8'h25);
    expect_rd("R10", 5'h07, 8'h33);
    tick_n(1); chk("R10", "hit at :31", {7'b0, alarm_hit}, 8'h00);
    tick_n(1); chk("R10", "hit at :32", {7'b0, alarm_hit}, 8'h00);
    tick_n(1); chk("R10", "hit at :33", {7'b0, alarm_hit}, 8'h01);
    @(negedge clk); chk("R10", "hit one cycle", {7'b0, alarm_hit}, 8'h00);
    wr(5'h0A, 8'h16); wr(5'h07, 8'h36);
    tick_n(1); chk("R10", "day mismatch :34", {7'b0, alarm_hit}, 8'h00);
    tick_n(1); chk("R10", "day mismatch :35", {7'b0, alarm_hit}, 8'h00);
    tick_n(1); chk("R10", "day mismatch :36", {7'b0, alarm_hit}, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL %s watchdog expired: got running expected finished", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule